// File: doc/BRIEF.md
# Pulse-Stepped DAC Code Register with Interface Auto-Detect

This block holds the 8-bit code that drives a current-output DAC. It also decides, from pin activity seen after reset, which of three interface modes is active. After reset it sits in one-wire pulse mode: every rising edge on the tick pin raises the upper six bits of the code by one, and the code wraps from the top back to zero. If the direction pin is ever seen low while chip select is high, the block moves for good into two-wire pulse mode. In that mode the direction pin picks up or down on each tick, and the code saturates at both ends.

A low on chip select at any time moves the block for good into three-wire mode. In three-wire mode a serial port elsewhere owns the register, so ticks no longer change the code. All three pins are asynchronous. They are brought into the system clock domain by a synchronizer. A tick step shows on the code output three clock edges after the pin rises.

Top module: `dacstep_top`

## Requirements
- R1: While `rst_i` is high, and on the first cycle after it falls, `mode_o` is 0 (one-wire) and `code_o` is 8'h80.
- R2: Once `sel_n_i` is seen low, `mode_o` becomes 2 (three-wire) and stays 2 until reset, whatever the pins do later; this wins over a two-wire move in the same cycle.
- R3: With `sel_n_i` high, a low on `dir_i` in one-wire mode sets `mode_o` to 1 (two-wire), which stays until reset even after `dir_i` returns high.
- R4: In pulse modes only a rising edge on `tick_i` changes the code, and by exactly one unit of bits [7:2] (4 LSBs); the change is visible three clock edges after the pin rises.
- R5: Bits [1:0] of `code_o` are always zero.
- R6: In one-wire mode a tick at 8'hFC gives 8'h00, so 63 ticks from 8'h80 give 8'h7C.
- R7: In two-wire mode a tick with `dir_i` high adds 4 and a tick with `dir_i` low subtracts 4.
- R8: In two-wire mode the code stops at 8'hFC going up and at 8'h00 going down, and never wraps.
- R9: In three-wire mode ticks leave `code_o` unchanged.
- R10: A tick that arrives together with the first low on `dir_i` counts as a decrement. A tick that arrives together with the first low on `sel_n_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| sel_n_i | input | 1 | Chip select, active low, asynchronous |
| tick_i | input | 1 | Step pulse pin, asynchronous |
| dir_i | input | 1 | Step direction, high = up, asynchronous |
| mode_o | output | 2 | 0 one-wire, 1 two-wire, 2 three-wire |
| code_o | output | 8 | DAC code |

## Verification
The assertions assume three things about the pins. Each level on `tick_i` lasts longer than the synchronizer depth, so every rising edge is seen once. `tick_i` is low while reset is applied. The direction level is settled when its tick edge is sampled. The stimulus changes pins only on falling clock edges and holds each tick level for at least three cycles. It keeps `tick_i` low through every reset. A behavioural model in the bench follows the same three-cycle pin latency and is compared against the outputs on every clock.

// File: rtl/dacstep_pkg.sv
package dacstep_pkg;

    typedef enum logic [1:0] {
        MODE_ONE_WIRE   = 2'd0,
        MODE_TWO_WIRE   = 2'd1,
        MODE_THREE_WIRE = 2'd2
    } mode_e;

    typedef struct packed {
        logic sel_n;
        logic dir;
        logic tick;
    } pins_t;

    typedef struct packed {
        logic fire;
        logic at_top;
        logic at_bot;
    } step_t;

    function automatic mode_e next_mode(mode_e cur, logic sel_n, logic dir);
        if (!sel_n)
            return MODE_THREE_WIRE;
        if (cur == MODE_ONE_WIRE && !dir)
            return MODE_TWO_WIRE;
        return cur;
    endfunction

endpackage

// File: rtl/dacstep_sync.sv
module dacstep_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i)
                stage_q[s] <= RST_VAL;
            else if (s == 0)
                stage_q[s] <= d_i;
            else
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dacstep_edge.sv
module dacstep_edge (
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

    // R4: one edge yields a single-cycle strobe
    a_r4_single_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);
endmodule

// File: rtl/dacstep_mode_detect.sv
module dacstep_mode_detect
    import dacstep_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  sel_n_i,
    input  logic  dir_i,
    output mode_e mode_q_o,
    output mode_e mode_nxt_o
);
    mode_e mode_q;

    assign mode_nxt_o = next_mode(mode_q, sel_n_i, dir_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) mode_q <= MODE_ONE_WIRE;
        else       mode_q <= mode_nxt_o;
    end

    assign mode_q_o = mode_q;

    a_r2_enter_three: assert property (@(posedge clk_i) disable iff (rst_i)
        !sel_n_i |=> mode_q == MODE_THREE_WIRE);
    a_r2_three_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_q == MODE_THREE_WIRE |=> mode_q == MODE_THREE_WIRE);
    a_r3_enter_two: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_n_i && !dir_i && mode_q != MODE_THREE_WIRE) |=> mode_q == MODE_TWO_WIRE);
    a_r3_no_return: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_q != MODE_ONE_WIRE |=> mode_q != MODE_ONE_WIRE);
endmodule

// File: rtl/dacstep_counter.sv
module dacstep_counter
    import dacstep_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int FINE_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rise_i,
    input  logic              dir_i,
    input  mode_e             mode_nxt_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int CW = CODE_W - FINE_W;
    localparam logic [CW-1:0] C_TOP = {CW{1'b1}};
    localparam logic [CW-1:0] C_MID = CW'(1) << (CW-1);

    logic [CW-1:0] coarse_q, coarse_d;
    step_t         st;

    always_comb begin
        st.fire   = rise_i && (mode_nxt_i != MODE_THREE_WIRE);
        st.at_top = (coarse_q == C_TOP);
        st.at_bot = (coarse_q == '0);
        coarse_d  = coarse_q;
        if (st.fire) begin
            unique case (mode_nxt_i)
                MODE_ONE_WIRE: coarse_d = coarse_q + 1'b1;
                MODE_TWO_WIRE: begin
                    if (dir_i && !st.at_top)       coarse_d = coarse_q + 1'b1;
                    else if (!dir_i && !st.at_bot) coarse_d = coarse_q - 1'b1;
                end
                default: coarse_d = coarse_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) coarse_q <= C_MID;
        else       coarse_q <= coarse_d;
    end

    assign code_o = {coarse_q, {FINE_W{1'b0}}};

    a_r4_hold_no_edge: assert property (@(posedge clk_i) disable iff (rst_i)
        !rise_i |=> $stable(coarse_q));
    a_r6_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise_i && mode_nxt_i == MODE_ONE_WIRE && coarse_q == C_TOP) |=> coarse_q == '0);
    a_r7_down_one: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise_i && mode_nxt_i == MODE_TWO_WIRE && !dir_i && coarse_q != '0)
        |=> coarse_q == CW'($past(coarse_q) - 1'b1));
    a_r8_sat_top: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise_i && mode_nxt_i == MODE_TWO_WIRE && dir_i && coarse_q == C_TOP) |=> coarse_q == C_TOP);
    a_r8_sat_bot: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise_i && mode_nxt_i == MODE_TWO_WIRE && !dir_i && coarse_q == '0) |=> coarse_q == '0);
    a_r9_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_nxt_i == MODE_THREE_WIRE |=> $stable(coarse_q));
endmodule

// File: rtl/dacstep_top.sv
module dacstep_top
    import dacstep_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int FINE_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sel_n_i,
    input  logic              tick_i,
    input  logic              dir_i,
    output logic [1:0]        mode_o,
    output logic [CODE_W-1:0] code_o
);
    localparam pins_t PIN_RST = '{sel_n: 1'b1, dir: 1'b1, tick: 1'b0};

    pins_t pins_raw, pins_s;
    logic  tick_rise;
    mode_e mode_q, mode_nxt;

    assign pins_raw = '{sel_n: sel_n_i, dir: dir_i, tick: tick_i};

    dacstep_sync #(.W($bits(pins_t)), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk_i(clk_i), .rst_i(rst_i), .d_i(pins_raw), .q_o(pins_s)
    );

    dacstep_edge u_edge (
        .clk_i(clk_i), .rst_i(rst_i), .lvl_i(pins_s.tick), .rise_o(tick_rise)
    );

    dacstep_mode_detect u_mode (
        .clk_i(clk_i), .rst_i(rst_i), .sel_n_i(pins_s.sel_n), .dir_i(pins_s.dir),
        .mode_q_o(mode_q), .mode_nxt_o(mode_nxt)
    );

    dacstep_counter #(.CODE_W(CODE_W), .FINE_W(FINE_W)) u_cnt (
        .clk_i(clk_i), .rst_i(rst_i), .rise_i(tick_rise), .dir_i(pins_s.dir),
        .mode_nxt_i(mode_nxt), .code_o(code_o)
    );

    assign mode_o = mode_q;

    // R1: reset values seen on the first cycle after release
    a_r1_reset_state: assert property (@(posedge clk_i)
        $fell(rst_i) |-> (mode_o == 2'd0 && code_o == CODE_W'(1) << (CODE_W-1)));
endmodule

// File: tb/tb_dacstep_top.sv
`timescale 1ns/1ps
module tb_dacstep_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1;
    logic       tick = 1'b0;
    logic       dir = 1'b1;
    logic [1:0] mode;
    logic [7:0] code;

    int nchecks = 0;
    int nfail   = 0;

    always #2.5 clk = ~clk;

    dacstep_top dut (
        .clk_i(clk), .rst_i(rst), .sel_n_i(sel_n), .tick_i(tick), .dir_i(dir),
        .mode_o(mode), .code_o(code)
    );

    // behavioural reference: pins are seen two clocks late, edges three
    int m_mode, m_code;
    bit live = 0;
    bit h_sel[3], h_dir[3], h_tick[3];

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_code = 128; live = 0;
            for (int i = 0; i < 3; i++) begin h_sel[i] = 1; h_dir[i] = 1; h_tick[i] = 0; end
        end else begin
            int nm;
            live = 1;
            if (!h_sel[1])                    nm = 2;
            else if (m_mode == 0 && !h_dir[1]) nm = 1;
            else                              nm = m_mode;
            if (h_tick[1] && !h_tick[2] && nm != 2) begin
                if (nm == 0)       m_code = (m_code == 252) ? 0 : m_code + 4;
                else if (h_dir[1]) m_code = (m_code >= 252) ? 252 : m_code + 4;
                else               m_code = (m_code <= 0) ? 0 : m_code - 4;
            end
            m_mode = nm;
            h_sel[2] = h_sel[1];  h_sel[1] = h_sel[0];  h_sel[0] = sel_n;
            h_dir[2] = h_dir[1];  h_dir[1] = h_dir[0];  h_dir[0] = dir;
            h_tick[2] = h_tick[1]; h_tick[1] = h_tick[0]; h_tick[0] = tick;
        end
    end

    task automatic check(string req, int act, int exp);
        nchecks++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R4 R2 R3: every-cycle comparison with the model
    always @(negedge clk) begin
        if (live) begin
            check("R4 model code", code, m_code);
            check("R2 model mode", mode, m_mode);
            check("R5 low bits", code[1:0], 0);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1; sel_n = 1; dir = 1; tick = 0;
        repeat (3) @(negedge clk);
        check("R1 mode in reset", mode, 0);
        check("R1 code in reset", code, 128);
        rst = 0;
        @(negedge clk);
        check("R1 mode after reset", mode, 0);
        check("R1 code after reset", code, 128);
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1;
            repeat (3) @(negedge clk);
            tick = 0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog all requirements: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end

    initial begin
        // one-wire: step and wrap
        do_reset();
        pulses(1);  settle();
        check("R4 one step", code, 8'h84);
        pulses(30); settle();
        check("R6 reach top", code, 8'hFC);
        pulses(1);  settle();
        check("R6 wrap to zero", code, 8'h00);
        pulses(31); settle();
        check("R6 63 ticks one step down", code, 8'h7C);
        check("R6 mode still one-wire", mode, 0);

        // two-wire: entry, direction, saturation
        do_reset();
        @(negedge clk) dir = 0; settle();
        check("R3 enter two-wire", mode, 1);
        check("R3 code kept", code, 8'h80);
        pulses(1);  settle();
        check("R7 down step", code, 8'h7C);
        pulses(33); settle();
        check("R8 bottom saturate", code, 8'h00);
        @(negedge clk) dir = 1; settle();
        check("R3 stays two-wire", mode, 1);
        pulses(1);  settle();
        check("R7 up step", code, 8'h04);
        pulses(70); settle();
        check("R8 top saturate", code, 8'hFC);

        // first down tick counts, then three-wire freezes
        do_reset();
        @(negedge clk) begin dir = 0; tick = 1; end
        settle();
        check("R10 first low tick decrements", code, 8'h7C);
        check("R10 mode two-wire", mode, 1);
        @(negedge clk) tick = 0; settle();
        @(negedge clk) sel_n = 0; settle();
        check("R2 enter three-wire", mode, 2);
        check("R2 code kept", code, 8'h7C);
        pulses(5); settle();
        check("R9 ticks ignored", code, 8'h7C);
        @(negedge clk) sel_n = 1; settle();
        check("R2 stays three-wire", mode, 2);
        @(negedge clk) dir = 1; pulses(2); settle();
        check("R9 up ticks ignored", code, 8'h7C);

        // simultaneous select, direction and tick
        do_reset();
        @(negedge clk) begin sel_n = 0; dir = 0; tick = 1; end
        settle();
        check("R2 priority over two-wire", mode, 2);
        check("R10 tick with select ignored", code, 8'h80);
        @(negedge clk) tick = 0; settle();

        // reset clears a sticky mode
        do_reset();
        pulses(2); settle();
        check("R1 one-wire after reset", mode, 0);
        check("R4 two steps", code, 8'h88);

        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end
endmodule